// File: doc/BRIEF.md
# Per-Pin Input Debouncer with Shared Period Timers

This block cleans up a bank of slow input pins, such as buttons, jumpers or board-level status lines, before other logic uses them. There are three period registers, each holding a count of clock cycles. Every pin has a 2-bit selector that picks one of the three periods or turns filtering off. Any number of pins may share one period, so many pins can be filtered with only three programmed values.

A filtered pin changes its output only after its raw input has held the new level for the selected number of clock edges. A shorter excursion is dropped. An unfiltered pin is connected straight through to its output. Software works out the cycle counts and decides which pins share a period. It writes the counts and selectors through a simple write port.

Top module: `dbn_bank`

## Requirements
- R1: After reset every register is 0. No pin is filtered, and `pin_clean` follows `pin_raw`.
- R2: A write (`wr_en`=1 at a rising edge) to address 0x00 loads the selector high bits, with pin n at bit n. Address 0x04 loads the selector low bits at the same positions. Addresses 0x10, 0x14 and 0x18 load the period for selector values 1, 2 and 3.
- R3: A pin whose selector is 0 drives `pin_clean` equal to `pin_raw` in the same cycle, with no clock delay.
- R4: A pin with a selector s≠0 and period P≥1 takes a new raw level onto `pin_clean` just after the P-th consecutive rising edge that samples that level. A period of 0 behaves like 1.
- R5: If the raw level returns to the filtered value before P edges have passed, `pin_clean` does not change. The next departure counts again from zero.
- R6: Pins with the same selector use the same period. Pins on different selectors time out independently.
- R7: Two kinds of write restart a pin's count without changing `pin_clean`: a write that changes the pin's selector, and any write to the period register the pin selects. The pin then needs P further edges after the write edge.
- R8: When a pin goes from selector 0 to a non-zero selector, filtering starts from the current raw level, so the output shows no spurious edge.
- R9: Writes to any other address change no selector and no period. A selector-0 pin still passes through, and a filtered pin keeps its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| pin_raw | input | NPINS | Raw pin levels |
| pin_clean | output | NPINS | Filtered pin levels |

## Verification
On every cycle the assertions check four things for each pin. A pin's count stays below its active period. A pin whose raw level equals its filtered level holds still with a zero count. A restart clears the count without moving the output. A bypassed pin's stored level tracks the raw input. Only the bench scenarios can show the exact edge at which a level is accepted, and that a short glitch is rejected. The same is true of sharing a period across pins, the extra delay a restart causes, and unmapped writes having no effect.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int NUM_TIMERS = 3;

    localparam logic [ADDR_W-1:0] ADDR_SEL_HI   = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_SEL_LO   = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_PER_BASE = 8'h10;

    typedef enum logic [1:0] {
        SEL_BYPASS = 2'd0,
        SEL_TMR1   = 2'd1,
        SEL_TMR2   = 2'd2,
        SEL_TMR3   = 2'd3
    } dbn_sel_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } dbn_wr_t;

    // Address of the period register that serves selector value k+1
    function automatic logic [ADDR_W-1:0] period_addr(input int k);
        return ADDR_PER_BASE + ADDR_W'(4 * k);
    endfunction
endpackage

// File: rtl/dbn_regs.sv
module dbn_regs
    import dbn_pkg::*;
#(
    parameter int NPINS    = 32,   // at most DATA_W
    parameter int PERIOD_W = 32    // at most DATA_W
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  dbn_wr_t                              wr,
    output logic [NPINS-1:0]                     sel_hi_q,
    output logic [NPINS-1:0]                     sel_lo_q,
    output logic [NUM_TIMERS-1:0][PERIOD_W-1:0]  period_q,
    output logic [NPINS-1:0]                     restart
);
    logic                  hit_hi;
    logic                  hit_lo;
    logic [NUM_TIMERS-1:0] hit_per;

    always_comb begin
        hit_hi = wr.en && (wr.addr == ADDR_SEL_HI);
        hit_lo = wr.en && (wr.addr == ADDR_SEL_LO);
        for (int k = 0; k < NUM_TIMERS; k++) begin
            hit_per[k] = wr.en && (wr.addr == period_addr(k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_hi_q <= '0;
            sel_lo_q <= '0;
        end else begin
            if (hit_hi) sel_hi_q <= wr.data[NPINS-1:0];
            if (hit_lo) sel_lo_q <= wr.data[NPINS-1:0];
        end
    end

    for (genvar k = 0; k < NUM_TIMERS; k++) begin : g_per
        always_ff @(posedge clk) begin
            if (rst)             period_q[k] <= '0;
            else if (hit_per[k]) period_q[k] <= wr.data[PERIOD_W-1:0];
        end
    end

    // Per-pin restart: selector value changes, or its chosen period is written
    always_comb begin
        for (int n = 0; n < NPINS; n++) begin
            restart[n] = (hit_hi && (wr.data[n] != sel_hi_q[n])) ||
                         (hit_lo && (wr.data[n] != sel_lo_q[n]));
            for (int k = 0; k < NUM_TIMERS; k++) begin
                if (hit_per[k] && ({sel_hi_q[n], sel_lo_q[n]} == 2'(k + 1)))
                    restart[n] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter
    import dbn_pkg::*;
#(
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                raw,
    input  dbn_sel_e            sel,
    input  logic [PERIOD_W-1:0] period,
    input  logic                restart,
    output logic                clean
);
    logic                filt_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (sel == SEL_BYPASS) begin
            filt_q <= raw;
            cnt_q  <= '0;
        end else if (restart || (raw == filt_q)) begin
            cnt_q  <= '0;
        end else if (cnt_nxt >= {1'b0, period}) begin
            filt_q <= raw;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_nxt[PERIOD_W-1:0];
        end
    end

    assign clean = (sel == SEL_BYPASS) ? raw : filt_q;

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sel != SEL_BYPASS) |-> ((cnt_q == '0) || (cnt_q < period)));

    // R5
    settle_chk: assert property (@(posedge clk) disable iff (rst)
        ((sel != SEL_BYPASS) && (raw == filt_q)) |=> ((cnt_q == '0) && $stable(filt_q)));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        ((sel != SEL_BYPASS) && restart) |=> ((cnt_q == '0) && $stable(filt_q)));

    // R8
    bypass_track_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_BYPASS) |=> (filt_q == $past(raw)));
endmodule

// File: rtl/dbn_bank.sv
module dbn_bank
    import dbn_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int PERIOD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [NPINS-1:0]  pin_raw,
    output logic [NPINS-1:0]  pin_clean
);
    dbn_wr_t                             wr;
    logic [NPINS-1:0]                    sel_hi_q;
    logic [NPINS-1:0]                    sel_lo_q;
    logic [NUM_TIMERS-1:0][PERIOD_W-1:0] period_q;
    logic [NPINS-1:0]                    restart;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    dbn_regs #(.NPINS(NPINS), .PERIOD_W(PERIOD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .sel_hi_q (sel_hi_q),
        .sel_lo_q (sel_lo_q),
        .period_q (period_q),
        .restart  (restart)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        dbn_sel_e            sel_n;
        logic [PERIOD_W-1:0] per_n;

        assign sel_n = dbn_sel_e'({sel_hi_q[n], sel_lo_q[n]});

        always_comb begin
            per_n = '0;
            for (int k = 0; k < NUM_TIMERS; k++) begin
                if (sel_n == dbn_sel_e'(k + 1)) per_n = period_q[k];
            end
        end

        dbn_pin_filter #(.PERIOD_W(PERIOD_W)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw     (pin_raw[n]),
            .sel     (sel_n),
            .period  (per_n),
            .restart (restart[n]),
            .clean   (pin_clean[n])
        );
    end
endmodule

// File: tb/test_dbn_bank.sv
module test_dbn_bank;
    localparam int NPINS = 32;
    localparam int P1 = 3, P2 = 5, P3 = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [NPINS-1:0]  pin_raw = '0;
    logic [NPINS-1:0]  pin_clean;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] sh_hi = '0, sh_lo = '0;

    always #5 clk = ~clk;

    dbn_bank #(.NPINS(NPINS), .PERIOD_W(32)) i_dbn_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_raw(pin_raw), .pin_clean(pin_clean)
    );

    // {sel[7:6], 2'b00, hold[3:0]}
    localparam logic [7:0] VEC [10] = '{8'h01, 8'h42, 8'h43, 8'h84, 8'h85,
                                        8'hC7, 8'hC8, 8'h46, 8'hC1, 8'h89};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_sel(input int pin, input logic [1:0] s);
        sh_hi[pin] = s[1];
        sh_lo[pin] = s[0];
        wr(8'h00, sh_hi);
        wr(8'h04, sh_lo);
    endtask

    function automatic int per_of(input logic [1:0] s);
        int p;
        p = (s == 2'd1) ? P1 : (s == 2'd2) ? P2 : P3;
        return (p == 0) ? 1 : p;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        pin_raw = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset pass-through", pin_clean, 32'hA5A5_0F0F);
        pin_raw = 32'h0000_FFFF; #1;
        chk("R1 R3 no filtering after reset", pin_clean, 32'h0000_FFFF);
        pin_raw = '0;
        @(negedge clk);

        // R2 program the three periods
        wr(8'h10, P1);
        wr(8'h14, P2);
        wr(8'h18, P3);

        // Table: pulse on pin 0 under various selectors and hold lengths
        for (int i = 0; i < 10; i++) begin
            logic [1:0] s;
            int L;
            logic expv;
            s = VEC[i][7:6];
            L = int'(VEC[i][3:0]);
            expv = (s == 2'd0) || (L >= per_of(s));
            set_sel(0, s);
            pin_raw[0] = 1'b1;
            repeat (L) @(negedge clk);
            chk($sformatf("R4 R2 vec %0d rise", i), 32'(pin_clean[0]), 32'(expv));
            pin_raw[0] = 1'b0;
            repeat (12) @(negedge clk);
            chk($sformatf("R4 vec %0d fall", i), 32'(pin_clean[0]), 32'd0);
        end

        // R6 shared period on pins 4 and 5, separate on pin 6
        set_sel(4, 2'd2); set_sel(5, 2'd2); set_sel(6, 2'd3);
        pin_raw[6:4] = 3'b111;
        repeat (4) @(negedge clk);
        chk("R6 before shared period", 32'(pin_clean[6:4]), 32'b000);
        @(negedge clk);
        chk("R6 shared period reached", 32'(pin_clean[6:4]), 32'b011);
        repeat (3) @(negedge clk);
        chk("R6 independent period reached", 32'(pin_clean[6:4]), 32'b111);

        // R5 glitch rejected, count restarts on the next departure
        set_sel(0, 2'd1);
        pin_raw[0] = 1'b1;
        repeat (2) @(negedge clk);
        pin_raw[0] = 1'b0;
        @(negedge clk);
        pin_raw[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 glitch rejected", 32'(pin_clean[0]), 32'd0);
        @(negedge clk);
        chk("R5 accepted after full period", 32'(pin_clean[0]), 32'd1);
        pin_raw[0] = 1'b0;
        repeat (6) @(negedge clk);

        // R7 period write restarts the count of pins on that period
        pin_raw[0] = 1'b1;
        @(negedge clk);
        wr(8'h10, P1);
        repeat (2) @(negedge clk);
        chk("R7 period write restarts", 32'(pin_clean[0]), 32'd0);
        @(negedge clk);
        chk("R7 accepted after restart", 32'(pin_clean[0]), 32'd1);

        // R7 selector change restarts (pin 1: 1 -> 3 -> 2)
        set_sel(1, 2'd1);
        pin_raw[1] = 1'b1;
        @(negedge clk);
        sh_hi[1] = 1'b1; wr(8'h00, sh_hi);
        sh_lo[1] = 1'b0; wr(8'h04, sh_lo);
        repeat (4) @(negedge clk);
        chk("R7 selector change restarts", 32'(pin_clean[1]), 32'd0);
        @(negedge clk);
        chk("R7 accepted on new period", 32'(pin_clean[1]), 32'd1);

        // R8 enabling filtering on a high pin gives no spurious edge
        pin_raw[2] = 1'b1; #1;
        chk("R3 bypass pin 2", 32'(pin_clean[2]), 32'd1);
        set_sel(2, 2'd1);
        chk("R8 no edge on enable", 32'(pin_clean[2]), 32'd1);
        repeat (3) @(negedge clk);
        chk("R8 still held", 32'(pin_clean[2]), 32'd1);

        // R9 unmapped write has no effect
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0000_0000);
        pin_raw[3] = 1'b1; #1;
        chk("R9 bypass pin 3 kept", 32'(pin_clean[3]), 32'd1);
        pin_raw[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 period 1 kept (early)", 32'(pin_clean[0]), 32'd1);
        @(negedge clk);
        chk("R9 period 1 kept (edge)", 32'(pin_clean[0]), 32'd0);

        // R4 period 0 acts as one cycle
        wr(8'h18, 32'd0);
        set_sel(7, 2'd3);
        pin_raw[7] = 1'b1;
        @(negedge clk);
        chk("R4 zero period one edge", 32'(pin_clean[7]), 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule